// File: doc/BRIEF.md
# Hit Buffer Drain and Inhibit Controller

This block sits between a group of per-channel hit buffers and one shared downstream FIFO. Each buffer belongs to one acquisition front-end. While acquisition runs, each buffer collects timestamped hit words. The block keeps a free-running timestamp counter for the front-ends to use. A single-cycle clear pulse sets that counter back to zero, and the clear must arrive while acquisition is inhibited.

A drain starts in one of two ways: a buffer reports full while acquisition is running, or the external inhibit level rises. When a drain starts, the block raises its own busy inhibit. It then empties the non-empty buffers one after another, from the lowest channel number to the highest. Each word goes out on a valid/ready port, with the source channel number in its top bits. Each word is offered at most once per pacing interval. When ready is low, the word is held and the drain keeps its position. The inhibit that gates acquisition is the OR of the busy inhibit and the external level, so filling restarts as soon as both are low.

Within one drain, channel numbers never decrease. A consumer can therefore treat a drop in the channel tag as the start of the next event.

Top module: `hitbuf_drain_ctrl`

## Requirements
- R1: When any buffer full flag is high and the external inhibit is low at a clock edge, while no drain runs, `drain_busy` is high after that edge.
- R2: An external inhibit level that is low at one edge and high at the next starts a drain at that second edge, even when every buffer is empty.
- R3: `inhibit_out` equals `drain_busy` OR `ext_inhibit` at all times after reset. Once both are low, acquisition resumes with no further command.
- R4: Words leave in ascending channel order, and in FIFO order within each channel. Each word is {channel[4:0] in bits 31:27, buffer data in bits 26:0}. At most one buffer is popped per cycle.
- R5: Empty buffers are skipped and never popped. A drain that finds every buffer empty keeps `drain_busy` high for exactly one cycle.
- R6: Two consecutive accepted output words are at least WORD_GAP clock cycles apart. This holds across the end of one drain and the start of the next.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable at the next edge. A buffer is popped only on an accepted word.
- R8: `drain_busy` stays high until the last word is accepted and falls at the second edge after that acceptance. By then every buffer is empty and every word stored has been delivered.
- R9: `timestamp` is zero during reset and after any edge that samples `time_clear` high. Otherwise it increases by one each cycle.
- R10: `out_valid` is high only while `drain_busy` is high, and it is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_inhibit | input | 1 | External inhibit level; its rising edge requests a drain |
| time_clear | input | 1 | Timestamp clear pulse |
| buf_full | input | NUM_CH | Per-channel buffer full flags |
| buf_empty | input | NUM_CH | Per-channel buffer empty flags |
| buf_rd_data | input | NUM_CH*(OUT_W-CH_W) | Head word of each buffer (show-ahead), channel c at slice c |
| buf_rd_en | output | NUM_CH | Per-channel pop strobe |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can accept (not full) |
| out_data | output | OUT_W | Channel-tagged output word |
| inhibit_out | output | 1 | Combined acquisition inhibit |
| drain_busy | output | 1 | Internal inhibit, high for the whole drain |
| timestamp | output | TS_W | Free-running time counter |

## Verification
The bench builds the block with six channels, a pacing interval of four cycles and buffer models eight words deep. The channel tag keeps its 5-bit field, so the output format is exactly the default one. With shallow buffers, a few pushes are enough to produce full-triggered drains, which makes it practical to mix them with drains started by the external edge, all-empty drains and drains that skip channels. Stretches of random back-pressure exercise the hold rule and make the pacing counter carry over from one drain into the next.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;

  typedef enum logic [0:0] {
    ST_ACQUIRE = 1'b0,
    ST_DRAIN   = 1'b1
  } drain_state_e;

endpackage

// File: rtl/hitbuf_timebase.sv
module hitbuf_timebase #(
  parameter int TS_W = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            time_clear,
  output logic [TS_W-1:0] ts
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ts <= '0;
    else if (time_clear) ts <= '0;
    else                 ts <= ts + 1'b1;
  end

  // clear pulse lands as zero on the next cycle
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    time_clear |=> (ts == '0));

endmodule

// File: rtl/hitbuf_next_pick.sv
module hitbuf_next_pick #(
  parameter int NUM_CH = 20,
  parameter int CH_W   = 5
) (
  input  logic [NUM_CH-1:0] avail,
  input  logic [CH_W-1:0]   base,
  output logic              found,
  output logic [CH_W-1:0]   idx
);

  logic [NUM_CH-1:0] elig;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_elig
    assign elig[g] = avail[g] && (CH_W'(g) >= base);
  end

  // lowest eligible channel wins
  always_comb begin
    found = |elig;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) idx = CH_W'(i);
    end
  end

endmodule

// File: rtl/hitbuf_pacer.sv
module hitbuf_pacer #(
  parameter int WORD_GAP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic slot_open
);

  localparam int GAP_W = $clog2(WORD_GAP) + 1;
  localparam logic [GAP_W-1:0] RELOAD = GAP_W'(WORD_GAP - 1);

  logic [GAP_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wait_cnt <= '0;
    else if (fire)            wait_cnt <= RELOAD;
    else if (wait_cnt != '0)  wait_cnt <= wait_cnt - 1'b1;
  end

  assign slot_open = (wait_cnt == '0);

endmodule

// File: rtl/hitbuf_drain_ctrl.sv
module hitbuf_drain_ctrl
  import hitbuf_pkg::*;
#(
  parameter int NUM_CH   = 20,
  parameter int CH_W     = 5,
  parameter int OUT_W    = 32,
  parameter int WORD_GAP = 10,
  parameter int TS_W     = 27
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ext_inhibit,
  input  logic                             time_clear,
  input  logic [NUM_CH-1:0]                buf_full,
  input  logic [NUM_CH-1:0]                buf_empty,
  input  logic [NUM_CH*(OUT_W-CH_W)-1:0]   buf_rd_data,
  output logic [NUM_CH-1:0]                buf_rd_en,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [OUT_W-1:0]                 out_data,
  output logic                             inhibit_out,
  output logic                             drain_busy,
  output logic [TS_W-1:0]                  timestamp
);

  localparam int DATA_W = OUT_W - CH_W;
  localparam int GAP_W  = $clog2(WORD_GAP) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(WORD_GAP - 1);

  drain_state_e     state;
  logic [CH_W-1:0]  cur_ch;
  logic             ext_q;
  logic             start_drain;
  logic             pick_found;
  logic [CH_W-1:0]  pick_idx;
  logic             slot_open;
  logic             fire;
  logic [DATA_W-1:0] sel_data;

  // ---------------- timestamp ----------------
  hitbuf_timebase #(.TS_W(TS_W)) i_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_clear(time_clear),
    .ts        (timestamp)
  );

  // ---------------- trigger and state ----------------
  assign start_drain = (|buf_full && !ext_inhibit) || (ext_inhibit && !ext_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ACQUIRE;
      cur_ch <= '0;
      ext_q  <= 1'b0;
    end else begin
      ext_q <= ext_inhibit;
      unique case (state)
        ST_ACQUIRE: begin
          if (start_drain) begin
            state  <= ST_DRAIN;
            cur_ch <= '0;
          end
        end
        ST_DRAIN: begin
          if (!pick_found) state  <= ST_ACQUIRE;
          else             cur_ch <= pick_idx;
        end
        default: state <= ST_ACQUIRE;
      endcase
    end
  end

  assign drain_busy  = (state == ST_DRAIN);
  assign inhibit_out = drain_busy | ext_inhibit;

  // ---------------- channel selection ----------------
  hitbuf_next_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_pick (
    .avail(~buf_empty),
    .base (cur_ch),
    .found(pick_found),
    .idx  (pick_idx)
  );

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pick_idx == CH_W'(i)) sel_data = buf_rd_data[i*DATA_W +: DATA_W];
    end
  end

  // ---------------- pacing and output ----------------
  hitbuf_pacer #(.WORD_GAP(WORD_GAP)) i_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .slot_open(slot_open)
  );

  assign out_valid = drain_busy && pick_found && slot_open;
  assign out_data  = {pick_idx, sel_data};
  assign fire      = out_valid && out_ready;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pop
    assign buf_rd_en[g] = fire && (pick_idx == CH_W'(g));
  end

  // ---------------- checks ----------------
  logic [GAP_W-1:0] since_fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_fire <= GAP_MAX;
    else if (fire)                 since_fire <= '0;
    else if (since_fire != GAP_MAX) since_fire <= since_fire + 1'b1;
  end

  assert_word_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_fire == GAP_MAX));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_rd_en));

  assert_no_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en & buf_empty) == '0);

  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_busy) |-> ($past(|buf_full && !ext_inhibit) ||
                           ($past(ext_inhibit) && !$past(ext_inhibit, 2))));

  assert_end_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_busy) |-> $past(&buf_empty));

endmodule

// File: tb/test_hitbuf_drain_ctrl.sv
module test_hitbuf_drain_ctrl;

  localparam int NUM_CH   = 6;
  localparam int CH_W     = 5;
  localparam int OUT_W    = 32;
  localparam int WORD_GAP = 4;
  localparam int TS_W     = 27;
  localparam int DATA_W   = OUT_W - CH_W;
  localparam int DEPTH    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_inhibit = 1'b0;
  logic time_clear = 1'b0;
  logic [NUM_CH-1:0] buf_full, buf_empty, buf_rd_en;
  logic [NUM_CH*DATA_W-1:0] buf_rd_data;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [OUT_W-1:0] out_data;
  logic inhibit_out, drain_busy;
  logic [TS_W-1:0] timestamp;

  int checks = 0, errors = 0;
  bit done = 0;
  bit bp_mode = 0;

  always #5 clk = ~clk;

  hitbuf_drain_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .OUT_W(OUT_W),
                      .WORD_GAP(WORD_GAP), .TS_W(TS_W)) i_hitbuf_drain_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_inhibit(ext_inhibit), .time_clear(time_clear),
    .buf_full(buf_full), .buf_empty(buf_empty), .buf_rd_data(buf_rd_data),
    .buf_rd_en(buf_rd_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .inhibit_out(inhibit_out), .drain_busy(drain_busy),
    .timestamp(timestamp));

  // ---------------- buffer models ----------------
  logic [DATA_W-1:0] mem [NUM_CH][DEPTH];
  int rp [NUM_CH];
  int wp [NUM_CH];
  int cnt [NUM_CH];
  int cyc = 0;
  int pushed_total = 0, accepted_total = 0;
  bit push_go = 0;
  int push_ch = 0;
  logic [DATA_W-1:0] push_val = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rp[c] <= 0; wp[c] <= 0; cnt[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        int d;
        d = 0;
        if (buf_rd_en[c] && cnt[c] > 0) begin
          rp[c] <= (rp[c] + 1) % DEPTH;
          d = d - 1;
        end
        if (push_go && push_ch == c && !inhibit_out && cnt[c] < DEPTH) begin
          mem[c][wp[c]] <= push_val;
          wp[c] <= (wp[c] + 1) % DEPTH;
          d = d + 1;
          pushed_total <= pushed_total + 1;
        end
        cnt[c] <= cnt[c] + d;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      buf_full[c]  = (cnt[c] == DEPTH);
      buf_empty[c] = (cnt[c] == 0);
      buf_rd_data[c*DATA_W +: DATA_W] = mem[c][rp[c]];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] expect_word();
    for (int c = 0; c < NUM_CH; c++)
      if (cnt[c] > 0) return {CH_W'(c), mem[c][rp[c]]};
    return '0;
  endfunction

  function automatic bit all_empty();
    for (int c = 0; c < NUM_CH; c++) if (cnt[c] != 0) return 0;
    return 1;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- output monitor ----------------
  bit prev_busy = 0, prev_stall = 0, have_last = 0;
  logic [OUT_W-1:0] prev_data = '0;
  int last_fire = 0, drain_words = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = bp_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
      check(inhibit_out == (drain_busy | ext_inhibit), "R3", inhibit_out, drain_busy | ext_inhibit);
      check(!out_valid || drain_busy, "R10", out_valid, drain_busy);
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R7", out_data, prev_data);
      if (out_valid && out_ready) begin
        check(out_data == expect_word(), "R4", out_data, expect_word());
        if (have_last)
          check(cyc + 1 - last_fire >= WORD_GAP, "R6", cyc + 1 - last_fire, WORD_GAP);
        last_fire = cyc + 1;
        have_last = 1;
        accepted_total++;
        drain_words++;
      end
      if (prev_busy && !drain_busy) begin
        check(all_empty(), "R8", 0, 1);
        check(accepted_total == pushed_total, "R8", accepted_total, pushed_total);
        if (drain_words > 0) check(cyc == last_fire + 1, "R8", cyc, last_fire + 1);
        drain_words = 0;
      end
      prev_busy  = drain_busy;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input int ch, input logic [DATA_W-1:0] v);
    push_go = 1; push_ch = ch; push_val = v;
    tick();
    push_go = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      if (!drain_busy) return;
      tick();
    end
    check(0, "R8", drain_busy, 0);
  endtask

  task automatic ext_pulse();
    ext_inhibit = 1;
    tick();
    ext_inhibit = 0;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    // reset state
    check(!out_valid && buf_rd_en == '0, "R10", out_valid, 0);
    check(!drain_busy && !inhibit_out, "R3", drain_busy, 0);
    check(timestamp == '0, "R9", timestamp, 0);
    rst_n = 1;
    tick();

    // R9: clear then count
    time_clear = 1;
    tick();
    time_clear = 0;
    check(timestamp == '0, "R9", timestamp, 0);
    repeat (5) tick();
    check(timestamp == 5, "R9", timestamp, 5);

    // R1 with R5 skipping: data on ch4 and ch1, then fill ch0
    for (int k = 0; k < 3; k++) push(4, DATA_W'(32'h400 + k));
    for (int k = 0; k < 2; k++) push(1, DATA_W'(32'h100 + k));
    for (int k = 0; k < DEPTH; k++) push(0, DATA_W'(32'h7000 + k));
    check(!drain_busy && buf_full[0], "R1", drain_busy, 0);
    tick();
    check(drain_busy && inhibit_out, "R1", drain_busy, 1);
    wait_idle();
    check(!inhibit_out, "R3", inhibit_out, 0);

    // R2: external edge with partial data, level held past drain end
    push(3, DATA_W'(32'h333));
    push(5, DATA_W'(32'h555));
    ext_inhibit = 1;
    tick();
    check(drain_busy, "R2", drain_busy, 1);
    wait_idle();
    repeat (2) tick();
    check(inhibit_out && !drain_busy, "R3", inhibit_out, 1);
    push(2, DATA_W'(32'h222));
    check(cnt[2] == 0, "R3", cnt[2], 0);
    ext_inhibit = 0;
    tick();
    check(!inhibit_out, "R3", inhibit_out, 0);
    push(2, DATA_W'(32'h223));
    check(cnt[2] == 1, "R3", cnt[2], 1);
    ext_pulse();
    wait_idle();

    // R5: all buffers empty, busy for exactly one cycle
    begin
      int hi;
      hi = 0;
      ext_inhibit = 1;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (drain_busy) hi++;
      end
      check(hi == 1, "R5", hi, 1);
      check(inhibit_out, "R3", inhibit_out, 1);
      ext_inhibit = 0;
      tick();
      check(!inhibit_out, "R3", inhibit_out, 0);
    end

    // random rounds, half with back-pressure (R6, R7)
    for (int r = 0; r < 30; r++) begin
      int n;
      bp_mode = r[0];
      n = $urandom_range(1, 16);
      for (int k = 0; k < n; k++)
        push($urandom_range(0, NUM_CH - 1), DATA_W'($urandom));
      if (!drain_busy) ext_pulse();
      wait_idle();
      tick();
    end
    bp_mode = 0;
    repeat (3) tick();
    check(accepted_total == pushed_total, "R8", accepted_total, pushed_total);
    finish_run();
  end

endmodule